// File: doc/BRIEF.md
# Linked-List Descriptor DMA Engine for an SD Data Port

This block moves a programmed number of bytes between system memory and the data port of an SD card interface. Software places a chain of 16-byte descriptors in memory and presents the chain's base address, the byte count, the block size, the direction and an enable. A start pulse then launches the engine. For each descriptor the engine fetches four 32-bit words from consecutive addresses. The first word is the status word (bit 31 hold, bit 30 error, bit 4 chained, bit 3 first, bit 2 last, bit 1 interrupt suppress), followed by the buffer size, the buffer address and the address of the next descriptor. The engine streams the buffer one 32-bit word at a time to or from the card, and writes the status word back with the hold bit released.

The chain ends when a descriptor with the last bit has been served or when the byte count is used up. The engine then raises sticky completion flags: data done, card event, summary, and one of transmit or receive. A memory error response stops the chain. The engine marks the failing descriptor with the error bit and raises an error flag instead of the completion flags.

The controller is built around one state machine. Its states are IDLE, WAIT_CARD, FETCH, MEM_BEAT, CARD_BEAT, GAP and WBACK. The transitions are:
- start: IDLE to FETCH, or IDLE to WAIT_CARD for a card read whose data is not yet ready.
- card ready: WAIT_CARD to FETCH.
- descriptor loaded: FETCH to the first beat state.
- beat turnaround: between MEM_BEAT and CARD_BEAT.
- chunk pause: into GAP and back to the first beat state.
- buffer done: to WBACK.
- chain follow: WBACK to FETCH.
- finish or abort: WBACK to IDLE.
- fault: FETCH or MEM_BEAT to WBACK.

Top module: `sdd_desc_dma`

## Requirements
- R1: After reset, busy is 0, no memory request or card handshake is active, all flags are 0 and the remaining count is 0.
- R2: A start pulse is ignored, with busy staying 0 and the remaining count not loaded, when the enable is low, the byte count is 0 or the block size is 0.
- R3: A descriptor is read as four words at its address plus 0, 4, 8 and 12, taken as status, size, buffer address and next address in that order.
- R4: A size of 0 means MAX_DESC_BYTES, and a larger size is clamped to MAX_DESC_BYTES. A descriptor moves ceil(min(size, remaining) / 4) words.
- R5: Buffer word i is at the buffer address with its two low bits cleared, plus 4*i.
- R6: To the card (dir_to_card=1), each word is read from memory and then sent on the transmit port in order. From the card, each received word is written to memory in order.
- R7: At most CHUNK_BYTES/4 data words pass without a pause. After that many words within a descriptor, one cycle with no memory request and no card handshake follows, unless that word was the descriptor's last.
- R8: After a descriptor's data, its status word is written back to the descriptor address with bit 31 cleared and all other bits kept.
- R9: The chain ends after a descriptor whose status bit 2 is set, or when the remaining count is 0. Otherwise the engine fetches the descriptor at the next address.
- R10: The remaining count loads the byte count on start and drops by 4 per word, saturating at 0. Reaching 0 sets the data-done flag.
- R11: On a normal end, the data-done, card-event and summary flags are set, with the transmit flag for a card write or the receive flag for a card read. An accepted start clears all flags.
- R12: For a card read, the engine waits with no memory request until card_data_ready is high.
- R13: A memory error ends the chain. The status word is written back with bit 30 set and bit 31 cleared, the error flag is set, and no completion flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch pulse |
| dir_to_card | input | 1 | 1 = memory to card, 0 = card to memory |
| dma_en | input | 1 | Engine enable |
| byte_count | input | 32 | Bytes to move |
| block_size | input | 32 | Card block size, must be non-zero |
| desc_base | input | 32 | Address of the first descriptor |
| card_data_ready | input | 1 | Card has read data available |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write access |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access completes this cycle |
| mem_err | input | 1 | Error response, valid with mem_ack |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| card_tx_valid | output | 1 | Word offered to the card |
| card_tx_data | output | 32 | Word to the card |
| card_tx_ready | input | 1 | Card accepts the word |
| card_rx_valid | input | 1 | Card offers a word |
| card_rx_data | input | 32 | Word from the card |
| card_rx_ready | output | 1 | Engine accepts a card word |
| busy | output | 1 | Engine is not idle |
| remain | output | 32 | Remaining byte count |
| flag_data_done | output | 1 | Data complete |
| flag_card_evt | output | 1 | Card event at completion |
| flag_summary | output | 1 | DMA summary |
| flag_tx_done | output | 1 | Transfer to card finished |
| flag_rx_done | output | 1 | Transfer from card finished |
| flag_error | output | 1 | Chain aborted on a memory error |

## Verification
Every memory access finishes in the cycle it is requested, because the bench memory acknowledges at once. The status write-back therefore follows the last data word by exactly one cycle. The completion or error flags and the fall of busy arrive on that same edge. The flags clear on the edge that accepts start. Data words are checked in order rather than at fixed cycles: the driver queues every expected memory write and transmitted word, and the monitor pops and compares one item on each handshake, sampling at the falling edge. Pauses between chunks are counted as busy cycles with no request or handshake. Flag, count and busy checks are taken at the falling edge after busy drops, or a fixed number of edges after start.

// File: rtl/sdd_pkg.sv
package sdd_pkg;

    localparam int unsigned WORD_BITS = 32;

    // status word bit positions, shared with software
    localparam int unsigned ST_HOLD = 31;
    localparam int unsigned ST_ERR  = 30;
    localparam int unsigned ST_LAST = 2;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WAIT_CARD,
        S_FETCH,
        S_MEM_BEAT,
        S_CARD_BEAT,
        S_GAP,
        S_WBACK
    } sdd_state_e;

    typedef struct packed {
        logic data_done;
        logic card_evt;
        logic summary;
        logic tx_done;
        logic rx_done;
        logic error;
    } sdd_flags_t;

endpackage

// File: rtl/sdd_size_clamp.sv
module sdd_size_clamp #(
    parameter int unsigned MAX_BYTES = 8192,
    parameter int unsigned CNT_W     = 12
) (
    input  logic [31:0]      desc_size,
    input  logic [31:0]      remain,
    output logic [CNT_W-1:0] words
);
    logic [31:0] eff_size;
    logic [31:0] take;

    always_comb begin
        if (desc_size == 32'd0 || desc_size > 32'(MAX_BYTES))
            eff_size = 32'(MAX_BYTES);
        else
            eff_size = desc_size;
        take  = (remain < eff_size) ? remain : eff_size;
        words = CNT_W'((take + 32'd3) >> 2);
    end
endmodule

// File: rtl/sdd_remain_ctr.sv
module sdd_remain_ctr (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic [31:0] load_val,
    input  logic        dec,
    output logic [31:0] remain,
    output logic        zero_hit
);
    assign zero_hit = dec && (remain != 32'd0) && (remain <= 32'd4);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            remain <= 32'd0;
        else if (load)
            remain <= load_val;
        else if (dec)
            remain <= (remain > 32'd4) ? remain - 32'd4 : 32'd0;
    end
endmodule

// File: rtl/sdd_flag_bank.sv
module sdd_flag_bank
    import sdd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  sdd_flags_t set,
    output sdd_flags_t q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else if (clr)
            q <= '0;
        else
            q <= q | set;
    end
endmodule

// File: rtl/sdd_desc_dma.sv
module sdd_desc_dma
    import sdd_pkg::*;
#(
    parameter int unsigned MAX_DESC_BYTES = 8192,
    parameter int unsigned CHUNK_BYTES    = 1024
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        dir_to_card,
    input  logic        dma_en,
    input  logic [31:0] byte_count,
    input  logic [31:0] block_size,
    input  logic [31:0] desc_base,
    input  logic        card_data_ready,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack,
    input  logic        mem_err,
    input  logic [31:0] mem_rdata,
    output logic        card_tx_valid,
    output logic [31:0] card_tx_data,
    input  logic        card_tx_ready,
    input  logic        card_rx_valid,
    input  logic [31:0] card_rx_data,
    output logic        card_rx_ready,
    output logic        busy,
    output logic [31:0] remain,
    output logic        flag_data_done,
    output logic        flag_card_evt,
    output logic        flag_summary,
    output logic        flag_tx_done,
    output logic        flag_rx_done,
    output logic        flag_error
);
    localparam int unsigned MAX_WORDS   = MAX_DESC_BYTES / 4;
    localparam int unsigned CNT_W       = $clog2(MAX_WORDS) + 1;
    localparam int unsigned CHUNK_WORDS = CHUNK_BYTES / 4;
    localparam int unsigned CHK_W       = $clog2(CHUNK_WORDS) + 1;

    sdd_state_e state, nxt;

    logic [31:0]       desc_addr;
    logic [1:0]        fetch_idx;
    logic [31:0]       stat_w;
    logic [31:0]       size_w;
    logic [29:0]       buf_w;
    logic [31:0]       next_w;
    logic              dir_q;
    logic              err_q;
    logic [CNT_W-1:0]  word_total;
    logic [CNT_W-1:0]  word_idx;
    logic [CHK_W-1:0]  chunk_cnt;
    logic [31:0]       data_q;
    logic [CNT_W-1:0]  words_w;

    logic       go_ok, accept, word_done, last_word, chunk_end;
    logic       wb_end, finish_ok, abort_now, zero_hit;
    sdd_state_e first_beat;
    sdd_flags_t flag_set, flags_q;

    assign go_ok      = dma_en && (byte_count != 32'd0) && (block_size != 32'd0);
    assign accept     = (state == S_IDLE) && start && go_ok;
    assign word_done  = ((state == S_MEM_BEAT) && mem_ack && !mem_err && !dir_q) ||
                        ((state == S_CARD_BEAT) && dir_q && card_tx_ready);
    assign last_word  = (word_idx == word_total - CNT_W'(1));
    assign chunk_end  = (chunk_cnt == CHK_W'(CHUNK_WORDS - 1));
    assign first_beat = dir_q ? S_MEM_BEAT : S_CARD_BEAT;
    assign wb_end     = err_q || mem_err || stat_w[ST_LAST] || (remain == 32'd0);
    assign finish_ok  = (state == S_WBACK) && mem_ack && !err_q && !mem_err &&
                        (stat_w[ST_LAST] || (remain == 32'd0));
    assign abort_now  = (state == S_WBACK) && mem_ack && (err_q || mem_err);

    sdd_size_clamp #(.MAX_BYTES(MAX_DESC_BYTES), .CNT_W(CNT_W)) u_clamp (
        .desc_size (size_w),
        .remain    (remain),
        .words     (words_w)
    );

    sdd_remain_ctr u_remain (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (byte_count),
        .dec      (word_done),
        .remain   (remain),
        .zero_hit (zero_hit)
    );

    always_comb begin
        flag_set           = '0;
        flag_set.data_done = zero_hit || finish_ok;
        flag_set.card_evt  = finish_ok;
        flag_set.summary   = finish_ok;
        flag_set.tx_done   = finish_ok && dir_q;
        flag_set.rx_done   = finish_ok && !dir_q;
        flag_set.error     = abort_now;
    end

    sdd_flag_bank u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (accept),
        .set   (flag_set),
        .q     (flags_q)
    );

    assign flag_data_done = flags_q.data_done;
    assign flag_card_evt  = flags_q.card_evt;
    assign flag_summary   = flags_q.summary;
    assign flag_tx_done   = flags_q.tx_done;
    assign flag_rx_done   = flags_q.rx_done;
    assign flag_error     = flags_q.error;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: begin
                if (accept)
                    nxt = (!dir_to_card && !card_data_ready) ? S_WAIT_CARD : S_FETCH;
            end
            S_WAIT_CARD: begin
                if (card_data_ready) nxt = S_FETCH;
            end
            S_FETCH: begin
                if (mem_ack) begin
                    if (mem_err)                nxt = S_WBACK;
                    else if (fetch_idx == 2'd3) nxt = first_beat;
                end
            end
            S_MEM_BEAT: begin
                if (mem_ack) begin
                    if (mem_err)    nxt = S_WBACK;
                    else if (dir_q) nxt = S_CARD_BEAT;
                    else if (last_word) nxt = S_WBACK;
                    else if (chunk_end) nxt = S_GAP;
                    else            nxt = S_CARD_BEAT;
                end
            end
            S_CARD_BEAT: begin
                if (dir_q) begin
                    if (card_tx_ready) begin
                        if (last_word)      nxt = S_WBACK;
                        else if (chunk_end) nxt = S_GAP;
                        else                nxt = S_MEM_BEAT;
                    end
                end else if (card_rx_valid) begin
                    nxt = S_MEM_BEAT;
                end
            end
            S_GAP: nxt = first_beat;
            S_WBACK: begin
                if (mem_ack) nxt = wb_end ? S_IDLE : S_FETCH;
            end
            default: nxt = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_req       = 1'b0;
        mem_we        = 1'b0;
        mem_addr      = 32'd0;
        mem_wdata     = 32'd0;
        card_tx_valid = 1'b0;
        card_rx_ready = 1'b0;
        unique case (state)
            S_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = desc_addr + 32'({fetch_idx, 2'b00});
            end
            S_MEM_BEAT: begin
                mem_req   = 1'b1;
                mem_we    = !dir_q;
                mem_addr  = {buf_w, 2'b00} + (32'(word_idx) << 2);
                mem_wdata = data_q;
            end
            S_CARD_BEAT: begin
                card_tx_valid = dir_q;
                card_rx_ready = !dir_q;
            end
            S_WBACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = desc_addr;
                mem_wdata = stat_w;
                mem_wdata[ST_HOLD] = 1'b0;
                mem_wdata[ST_ERR]  = stat_w[ST_ERR] | err_q;
            end
            default: ;
        endcase
    end

    assign card_tx_data = data_q;
    assign busy         = (state != S_IDLE);

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            desc_addr  <= 32'd0;
            fetch_idx  <= 2'd0;
            stat_w     <= 32'd0;
            size_w     <= 32'd0;
            buf_w      <= 30'd0;
            next_w     <= 32'd0;
            dir_q      <= 1'b0;
            err_q      <= 1'b0;
            word_total <= '0;
            word_idx   <= '0;
            chunk_cnt  <= '0;
            data_q     <= 32'd0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (accept) begin
                        desc_addr <= desc_base;
                        dir_q     <= dir_to_card;
                        err_q     <= 1'b0;
                        fetch_idx <= 2'd0;
                        stat_w    <= 32'd0;
                    end
                end
                S_FETCH: begin
                    if (mem_ack) begin
                        if (mem_err) begin
                            err_q     <= 1'b1;
                            fetch_idx <= 2'd0;
                        end else begin
                            unique case (fetch_idx)
                                2'd0: stat_w <= mem_rdata;
                                2'd1: size_w <= mem_rdata;
                                2'd2: buf_w  <= mem_rdata[31:2];
                                2'd3: next_w <= mem_rdata;
                                default: ;
                            endcase
                            fetch_idx <= fetch_idx + 2'd1;
                            if (fetch_idx == 2'd3) begin
                                word_total <= words_w;
                                word_idx   <= '0;
                                chunk_cnt  <= '0;
                            end
                        end
                    end
                end
                S_MEM_BEAT: begin
                    if (mem_ack) begin
                        if (mem_err)    err_q  <= 1'b1;
                        else if (dir_q) data_q <= mem_rdata;
                    end
                end
                S_CARD_BEAT: begin
                    if (!dir_q && card_rx_valid) data_q <= card_rx_data;
                end
                S_WBACK: begin
                    if (mem_ack && !wb_end) begin
                        desc_addr <= next_w;
                        stat_w    <= 32'd0;
                    end
                end
                default: ;
            endcase
            if (word_done) begin
                word_idx  <= word_idx + CNT_W'(1);
                chunk_cnt <= chunk_end ? '0 : chunk_cnt + CHK_W'(1);
            end
        end
    end
endmodule

// File: rtl/sdd_desc_dma_chk.sv
module sdd_desc_dma_chk
    import sdd_pkg::*;
#(
    parameter int unsigned CHUNK_WORDS = 256
) (
    input logic        clk,
    input logic        rst_n,
    input sdd_state_e  state,
    input logic        busy,
    input logic        mem_req,
    input logic        mem_we,
    input logic [31:0] mem_wdata,
    input logic        card_tx_valid,
    input logic        card_tx_ready,
    input logic        card_rx_valid,
    input logic        card_rx_ready,
    input logic [31:0] remain,
    input logic        flag_data_done,
    input logic        flag_summary,
    input logic        flag_tx_done,
    input logic        flag_rx_done,
    input logic        flag_error
);
    logic [15:0] beat_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            beat_run <= 16'd0;
        else if (state == S_GAP || state == S_FETCH)
            beat_run <= 16'd0;
        else if ((card_tx_valid && card_tx_ready) || (card_rx_ready && card_rx_valid))
            beat_run <= beat_run + 16'd1;
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !card_tx_valid && !card_rx_ready));

    p_one_direction_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(card_tx_valid && card_rx_ready));

    p_chunk_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        beat_run <= 16'(CHUNK_WORDS));

    p_hold_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WBACK && mem_req && mem_we) |-> !mem_wdata[ST_HOLD]);

    p_remain_falls_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (remain <= $past(remain)));

    p_done_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_summary) |-> (flag_data_done && (flag_tx_done ^ flag_rx_done)));

    p_error_no_done_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_error) |-> !flag_summary);
endmodule

bind sdd_desc_dma sdd_desc_dma_chk #(.CHUNK_WORDS(CHUNK_WORDS)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .state          (state),
    .busy           (busy),
    .mem_req        (mem_req),
    .mem_we         (mem_we),
    .mem_wdata      (mem_wdata),
    .card_tx_valid  (card_tx_valid),
    .card_tx_ready  (card_tx_ready),
    .card_rx_valid  (card_rx_valid),
    .card_rx_ready  (card_rx_ready),
    .remain         (remain),
    .flag_data_done (flag_data_done),
    .flag_summary   (flag_summary),
    .flag_tx_done   (flag_tx_done),
    .flag_rx_done   (flag_rx_done),
    .flag_error     (flag_error)
);

// File: tb/test_sdd_desc_dma.sv
module test_sdd_desc_dma;
    localparam int unsigned MAXB = 8192;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        dir_to_card = 1'b0;
    logic        dma_en = 1'b0;
    logic [31:0] byte_count = 32'd0;
    logic [31:0] block_size = 32'd0;
    logic [31:0] desc_base = 32'd0;
    logic        card_data_ready = 1'b1;
    logic        mem_req, mem_we, mem_ack, mem_err;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        card_tx_valid, card_rx_ready;
    logic [31:0] card_tx_data, card_rx_data;
    logic        card_tx_ready = 1'b1;
    logic        card_rx_valid = 1'b1;
    logic        busy;
    logic [31:0] remain;
    logic        flag_data_done, flag_card_evt, flag_summary;
    logic        flag_tx_done, flag_rx_done, flag_error;

    always #10 clk = ~clk;

    sdd_desc_dma #(.MAX_DESC_BYTES(MAXB), .CHUNK_BYTES(1024)) i_sdd_desc_dma (
        .clk(clk), .rst_n(rst_n), .start(start), .dir_to_card(dir_to_card),
        .dma_en(dma_en), .byte_count(byte_count), .block_size(block_size),
        .desc_base(desc_base), .card_data_ready(card_data_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
        .card_tx_valid(card_tx_valid), .card_tx_data(card_tx_data),
        .card_tx_ready(card_tx_ready), .card_rx_valid(card_rx_valid),
        .card_rx_data(card_rx_data), .card_rx_ready(card_rx_ready),
        .busy(busy), .remain(remain),
        .flag_data_done(flag_data_done), .flag_card_evt(flag_card_evt),
        .flag_summary(flag_summary), .flag_tx_done(flag_tx_done),
        .flag_rx_done(flag_rx_done), .flag_error(flag_error)
    );

    // ---------------- memory model: 16 KiB, error above ----------------
    logic [31:0] bmem [0:4095];
    logic        bvld [0:4095];
    logic        pl_en = 1'b0;
    logic [11:0] pl_a = 12'd0;
    logic [31:0] pl_d = 32'd0;

    function automatic logic [31:0] pat(input logic [11:0] i);
        return 32'h1000_0000 ^ (32'(i) * 32'h0000_9E37);
    endfunction

    function automatic logic [31:0] mdl(input logic [31:0] a);
        return bvld[a[13:2]] ? bmem[a[13:2]] : pat(a[13:2]);
    endfunction

    assign mem_ack   = mem_req;
    assign mem_err   = mem_req && (mem_addr[31:14] != 18'd0);
    assign mem_rdata = mdl(mem_addr);

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4096; i++) bvld[i] <= 1'b0;
        end else if (pl_en) begin
            bmem[pl_a] <= pl_d;
            bvld[pl_a] <= 1'b1;
        end else if (mem_req && mem_we && !mem_err) begin
            bmem[mem_addr[13:2]] <= mem_wdata;
            bvld[mem_addr[13:2]] <= 1'b1;
        end
    end

    // card receive source
    logic [31:0] rx_cnt = 32'd0;
    assign card_rx_data = 32'hC0DE_0000 + rx_cnt;
    always @(posedge clk) if (card_rx_valid && card_rx_ready) rx_cnt <= rx_cnt + 32'd1;

    // ---------------- scoreboard ----------------
    int checks = 0;
    int fails  = 0;
    logic [31:0] q_wa[$];
    logic [31:0] q_wd[$];
    string       q_wt[$];
    logic [31:0] q_tx[$];
    string       q_tt[$];
    int          gap_cnt = 0;
    logic [31:0] m_rem;
    logic [31:0] exp_rx_n = 32'd0;

    task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_req && mem_we) begin
                if (q_wa.size() == 0) begin
                    chk(1'b0, "R6 unexpected memory write", mem_addr, 32'd0);
                end else begin
                    logic [31:0] ea, ed;
                    string t;
                    ea = q_wa.pop_front(); ed = q_wd.pop_front(); t = q_wt.pop_front();
                    chk(mem_addr == ea, {t, " write address"}, mem_addr, ea);
                    chk(mem_wdata == ed, {t, " write data"}, mem_wdata, ed);
                end
            end
            if (card_tx_valid && card_tx_ready) begin
                if (q_tx.size() == 0) begin
                    chk(1'b0, "R6 unexpected card word", card_tx_data, 32'd0);
                end else begin
                    logic [31:0] ed;
                    string t;
                    ed = q_tx.pop_front(); t = q_tt.pop_front();
                    chk(card_tx_data == ed, {t, " card word"}, card_tx_data, ed);
                end
            end
            if (busy && !mem_req && !card_tx_valid && !card_rx_ready) gap_cnt++;
        end
    end

    // ---------------- driver tasks ----------------
    task automatic pl(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk); pl_en = 1'b1; pl_a = a[13:2]; pl_d = d;
        @(negedge clk); pl_en = 1'b0;
    endtask

    task automatic put_desc(input logic [31:0] a, input logic [31:0] st, input logic [31:0] sz,
                            input logic [31:0] bp, input logic [31:0] nx);
        pl(a, st); pl(a + 32'd4, sz); pl(a + 32'd8, bp); pl(a + 32'd12, nx);
    endtask

    // queue the expected traffic of one descriptor, updating m_rem
    task automatic exp_desc(input logic [31:0] da, input logic [31:0] st, input logic [31:0] sz,
                            input logic [31:0] bp, input logic dir, input string tag);
        logic [31:0] eff, take, a;
        int words;
        eff   = (sz == 32'd0 || sz > 32'(MAXB)) ? 32'(MAXB) : sz;
        take  = (m_rem < eff) ? m_rem : eff;
        words = int'((take + 32'd3) / 32'd4);
        for (int i = 0; i < words; i++) begin
            a = {bp[31:2], 2'b00} + 32'(4 * i);
            if (dir) begin
                q_tx.push_back(mdl(a)); q_tt.push_back(tag);
            end else begin
                q_wa.push_back(a); q_wd.push_back(32'hC0DE_0000 + exp_rx_n);
                q_wt.push_back(tag);
                exp_rx_n = exp_rx_n + 32'd1;
            end
            m_rem = (m_rem > 32'd4) ? m_rem - 32'd4 : 32'd0;
        end
        q_wa.push_back(da); q_wd.push_back(st & 32'h7FFF_FFFF); q_wt.push_back("R8");
    endtask

    task automatic launch(input logic dir, input logic en, input logic [31:0] cnt,
                          input logic [31:0] blk, input logic [31:0] base);
        @(negedge clk);
        dir_to_card = dir; dma_en = en; byte_count = cnt; block_size = blk;
        desc_base = base; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 30000; i++) begin
            if (!busy) break;
            @(negedge clk);
        end
    endtask

    // watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // ---------------- tests ----------------
    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(!busy && !mem_req && !card_tx_valid && !card_rx_ready, "R1 idle outputs",
            {28'd0, busy, mem_req, card_tx_valid, card_rx_ready}, 32'd0);
        chk({flag_data_done, flag_card_evt, flag_summary, flag_tx_done, flag_rx_done,
             flag_error} == 6'd0, "R1 flags", {26'd0, flag_data_done, flag_card_evt,
             flag_summary, flag_tx_done, flag_rx_done, flag_error}, 32'd0);
        chk(remain == 32'd0, "R1 remain", remain, 32'd0);

        // R2 gated starts
        launch(1'b1, 1'b0, 32'd64, 32'd512, 32'h100);
        repeat (3) @(negedge clk);
        chk(!busy && remain == 32'd0, "R2 disabled", remain, 32'd0);
        launch(1'b1, 1'b1, 32'd0, 32'd512, 32'h100);
        repeat (3) @(negedge clk);
        chk(!busy && remain == 32'd0, "R2 zero count", {31'd0, busy}, 32'd0);
        launch(1'b1, 1'b1, 32'd64, 32'd0, 32'h100);
        repeat (3) @(negedge clk);
        chk(!busy && remain == 32'd0, "R2 zero block size", remain, 32'd0);

        // R3 R5 R10 R11: single descriptor to card, count 6, unaligned buffer
        put_desc(32'h100, 32'h8000_000C, 32'd64, 32'h0000_1003, 32'h0);
        m_rem = 32'd6;
        exp_desc(32'h100, 32'h8000_000C, 32'd64, 32'h0000_1003, 1'b1, "R3 R5");
        launch(1'b1, 1'b1, 32'd6, 32'd512, 32'h100);
        wait_idle();
        chk(remain == 32'd0, "R10 saturated remain", remain, 32'd0);
        chk(flag_data_done && flag_card_evt && flag_summary && flag_tx_done && !flag_rx_done
            && !flag_error, "R11 tx completion flags", {26'd0, flag_data_done, flag_card_evt,
            flag_summary, flag_tx_done, flag_rx_done, flag_error}, 32'h3C);

        // R6 R9 R12: card read, two chained descriptors, ends on last bit
        put_desc(32'h200, 32'h8000_0010, 32'd12, 32'h0000_2000, 32'h240);
        put_desc(32'h240, 32'h8000_0004, 32'd8,  32'h0000_2100, 32'h280);
        m_rem = 32'd100;
        exp_desc(32'h200, 32'h8000_0010, 32'd12, 32'h0000_2000, 1'b0, "R6");
        exp_desc(32'h240, 32'h8000_0004, 32'd8,  32'h0000_2100, 1'b0, "R6");
        card_data_ready = 1'b0;
        launch(1'b0, 1'b1, 32'd100, 32'd512, 32'h200);
        chk(!flag_summary && !flag_tx_done, "R11 flags cleared on start",
            {31'd0, flag_summary}, 32'd0);
        repeat (4) @(negedge clk);
        chk(busy && !mem_req && !card_rx_ready, "R12 waits for card data",
            {30'd0, busy, mem_req}, 32'd2);
        card_data_ready = 1'b1;
        wait_idle();
        chk(remain == 32'd80, "R9 chain stopped at last bit", remain, 32'd80);
        chk(flag_rx_done && !flag_tx_done && flag_summary && flag_data_done,
            "R11 rx completion flags", {28'd0, flag_rx_done, flag_tx_done, flag_summary,
            flag_data_done}, 32'hB);

        // R4 R7 R9: size 0, oversize, count-limited third descriptor
        put_desc(32'h300, 32'h8000_0000, 32'd0,     32'h0000_2000, 32'h340);
        put_desc(32'h340, 32'h8000_0010, 32'd40000, 32'h0000_2000, 32'h380);
        put_desc(32'h380, 32'h8000_0000, 32'd16,    32'h0000_2000, 32'h3C0);
        m_rem = 32'd16396;
        exp_desc(32'h300, 32'h8000_0000, 32'd0,     32'h0000_2000, 1'b1, "R4");
        exp_desc(32'h340, 32'h8000_0010, 32'd40000, 32'h0000_2000, 1'b1, "R4");
        exp_desc(32'h380, 32'h8000_0000, 32'd16,    32'h0000_2000, 1'b1, "R4");
        gap_cnt = 0;
        launch(1'b1, 1'b1, 32'd16396, 32'd512, 32'h300);
        wait_idle();
        chk(gap_cnt == 14, "R7 chunk pauses", 32'(gap_cnt), 32'd14);
        chk(remain == 32'd0, "R9 chain stopped by count", remain, 32'd0);
        chk(q_tx.size() == 0, "R4 all card words sent", 32'(q_tx.size()), 32'd0);

        // R13: buffer in the error region
        put_desc(32'h400, 32'h8000_000C, 32'd8, 32'h0010_0000, 32'h0);
        q_wa.push_back(32'h400); q_wd.push_back(32'h4000_000C); q_wt.push_back("R13");
        launch(1'b1, 1'b1, 32'd8, 32'd512, 32'h400);
        wait_idle();
        chk(flag_error && !flag_summary && !flag_tx_done && !flag_data_done,
            "R13 error flags", {28'd0, flag_error, flag_summary, flag_tx_done,
            flag_data_done}, 32'h8);
        chk(remain == 32'd8, "R13 no data moved", remain, 32'd8);

        repeat (3) @(negedge clk);
        chk(q_wa.size() == 0, "R8 all memory writes seen", 32'(q_wa.size()), 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule